// File: doc/BRIEF.md
# Scaler phase parameter calculator

This block turns a pair of layer sizes into the setup words for a single-layer image scaler. The source size of each axis arrives in unsigned 16.16 fixed point and the destination size arrives as a whole pixel count. For each axis the block returns three values: the upscale ratio in 16.16, the per-pixel phase step, and the starting phase. It also returns two flags. One turns on the detail enhancer and the other turns the scaler on.

A mask with one bit per layer says which layers ask for scaling. The scaler can serve only one layer, so the mask is checked before any arithmetic. A start pulse launches one calculation and a done pulse marks the cycle in which the results are valid. An error flag reports a request the scaler cannot take. One restoring divider produces a quotient bit per cycle and carries all of the divisions one after another.

Top module: `scl_phase_calc`

## Requirements
- R1: A start with an all-zero layer mask raises `done_o` on the next cycle with `scale_en_o`=0, `err_o`=0 and every result zero. No size is checked in this case.
- R2: A start with two or more mask bits set raises `done_o` on the next cycle with `err_o`=1, `scale_en_o`=0 and every result zero.
- R3: A start with exactly one mask bit set and a zero value on any source or destination size raises `done_o` on the next cycle with `err_o`=1 and all results zero. The divider is not run.
- R4: Each axis ratio equals (destination << 32) / source, keeping the low 32 bits of the quotient.
- R5: Each axis phase step equals ((source >> 16) << 16) / destination.
- R6: Each axis starting phase equals (((source >> 16) << 4) / destination + 1) / 2.
- R7: `enh_en_o` is 1 when bits [31:16] of either axis ratio are 2 or more, and 0 otherwise.
- R8: For a valid request, `busy_o` is high from the cycle after the start until `done_o`. At `done_o` the flags read `scale_en_o`=1 and `err_o`=0.
- R9: A start while `busy_o` is high has no effect. A start in the cycle that shows `done_o` is accepted.
- R10: After reset, `busy_o`, `done_o`, `err_o`, both flags and all results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one calculation |
| req_mask_i | input | LAYERS | One bit per layer asking for scaling |
| src_w_i | input | SRC_W | Source width, U16.16 |
| src_h_i | input | SRC_W | Source height, U16.16 |
| dst_w_i | input | DST_W | Destination width in pixels |
| dst_h_i | input | DST_W | Destination height in pixels |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | Results valid, one-cycle pulse |
| err_o | output | 1 | Request rejected |
| scale_en_o | output | 1 | Scaler enable |
| enh_en_o | output | 1 | Detail enhancer enable |
| h_fact_o | output | SRC_W | Horizontal ratio, U16.16 |
| v_fact_o | output | SRC_W | Vertical ratio, U16.16 |
| h_init_o | output | 20 | Horizontal starting phase |
| v_init_o | output | 20 | Vertical starting phase |
| h_delta_o | output | 32 | Horizontal phase step |
| v_delta_o | output | 32 | Vertical phase step |

## Verification
Completion of one calculation and acceptance of the next request can fall in the same cycle. This happens because `done_o` is raised as the controller returns to idle. The bench provokes this by driving a new start on the same half-cycle in which it first sees `done_o`. The scoreboard must then receive both result sets in order with no extra completion.

A second test presents a start in the middle of a run, and it must produce no result at all. Any unexpected `done_o` is flagged against the queue.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;
  localparam int unsigned FRAC_BITS   = 16;
  localparam int unsigned PH_CNT_BITS = 4;
  localparam int unsigned PH_SHIFT    = 12;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } st_e;
endpackage

// File: rtl/scl_phase_div.sv
module scl_phase_div #(
  parameter int unsigned NUM_W = 48,
  parameter int unsigned DEN_W = 32,
  parameter int unsigned QUO_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [QUO_W-1:0] quo_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W);

  logic [DEN_W-1:0] rem_q, den_q, rem_nx;
  logic [NUM_W-1:0] nq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, ge;
  logic [DEN_W:0]   rem_sh;

  always_comb begin
    rem_sh = {rem_q, nq_q[NUM_W-1]};
    ge     = rem_sh >= {1'b0, den_q};
    rem_nx = DEN_W'(ge ? (rem_sh - {1'b0, den_q}) : rem_sh);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      nq_q   <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        den_q <= den_i;
        nq_q  <= num_i;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_nx;
        nq_q  <= {nq_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(NUM_W - 1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = nq_q[QUO_W-1:0];
endmodule

// File: rtl/scl_phase_mask_chk.sv
module scl_phase_mask_chk #(
  parameter int unsigned LAYERS = 4
) (
  input  logic [LAYERS-1:0] mask_i,
  output logic              none_o,
  output logic              multi_o
);
  assign none_o  = ~|mask_i;
  assign multi_o = |(mask_i & (mask_i - LAYERS'(1)));
endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import scl_phase_pkg::*;
#(
  parameter int unsigned LAYERS = 4,
  parameter int unsigned DST_W  = 16,
  parameter int unsigned SRC_W  = DST_W + FRAC_BITS,
  localparam int unsigned INT_W  = SRC_W - FRAC_BITS,
  localparam int unsigned DLT_W  = INT_W + PH_CNT_BITS + PH_SHIFT,
  localparam int unsigned INIT_W = DLT_W - PH_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LAYERS-1:0] req_mask_i,
  input  logic [SRC_W-1:0]  src_w_i,
  input  logic [SRC_W-1:0]  src_h_i,
  input  logic [DST_W-1:0]  dst_w_i,
  input  logic [DST_W-1:0]  dst_h_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              scale_en_o,
  output logic              enh_en_o,
  output logic [SRC_W-1:0]  h_fact_o,
  output logic [SRC_W-1:0]  v_fact_o,
  output logic [INIT_W-1:0] h_init_o,
  output logic [INIT_W-1:0] v_init_o,
  output logic [DLT_W-1:0]  h_delta_o,
  output logic [DLT_W-1:0]  v_delta_o
);
  localparam int unsigned NUM_W = DST_W + 2 * FRAC_BITS;
  localparam int unsigned DEN_W = SRC_W;
  localparam int unsigned QUO_W = (SRC_W > DLT_W) ? SRC_W : DLT_W;

  st_e              st_q;
  logic [1:0]       op_q;
  logic [SRC_W-1:0] sw_q, sh_q;
  logic [DST_W-1:0] dw_q, dh_q;
  logic             none, multi, size_zero;
  logic             div_start, div_done;
  logic [NUM_W-1:0] div_num;
  logic [DEN_W-1:0] div_den;
  logic [QUO_W-1:0] quo;
  logic [INIT_W:0]  init_sum;
  logic [INIT_W-1:0] init_val;

  scl_phase_mask_chk #(.LAYERS(LAYERS)) mask_i (
    .mask_i (req_mask_i),
    .none_o (none),
    .multi_o(multi)
  );

  assign size_zero = ~|src_w_i | ~|src_h_i | ~|dst_w_i | ~|dst_h_i;
  assign div_start = (st_q == ST_ISSUE);
  assign busy_o    = (st_q != ST_IDLE);

  // ops 0/1: ratio per axis, ops 2/3: phase step per axis
  always_comb begin
    case (op_q)
      2'd0: begin
        div_num = {dw_q, {(2 * FRAC_BITS){1'b0}}};
        div_den = sw_q;
      end
      2'd1: begin
        div_num = {dh_q, {(2 * FRAC_BITS){1'b0}}};
        div_den = sh_q;
      end
      2'd2: begin
        div_num = NUM_W'({sw_q[SRC_W-1:FRAC_BITS], {(PH_CNT_BITS + PH_SHIFT){1'b0}}});
        div_den = DEN_W'(dw_q);
      end
      default: begin
        div_num = NUM_W'({sh_q[SRC_W-1:FRAC_BITS], {(PH_CNT_BITS + PH_SHIFT){1'b0}}});
        div_den = DEN_W'(dh_q);
      end
    endcase
  end

  scl_phase_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .QUO_W(QUO_W)) div_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .quo_o  (quo)
  );

  // starting phase = round-half of (step >> shift); equals the direct division
  always_comb begin
    init_sum = {1'b0, quo[DLT_W-1:PH_SHIFT]} + (INIT_W + 1)'(1);
    init_val = INIT_W'(init_sum >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      op_q       <= '0;
      sw_q       <= '0;
      sh_q       <= '0;
      dw_q       <= '0;
      dh_q       <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      scale_en_o <= 1'b0;
      enh_en_o   <= 1'b0;
      h_fact_o   <= '0;
      v_fact_o   <= '0;
      h_init_o   <= '0;
      v_init_o   <= '0;
      h_delta_o  <= '0;
      v_delta_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            scale_en_o <= 1'b0;
            enh_en_o   <= 1'b0;
            h_fact_o   <= '0;
            v_fact_o   <= '0;
            h_init_o   <= '0;
            v_init_o   <= '0;
            h_delta_o  <= '0;
            v_delta_o  <= '0;
            if (none) begin
              err_o  <= 1'b0;
              done_o <= 1'b1;
            end else if (multi || size_zero) begin
              err_o  <= 1'b1;
              done_o <= 1'b1;
            end else begin
              err_o <= 1'b0;
              sw_q  <= src_w_i;
              sh_q  <= src_h_i;
              dw_q  <= dst_w_i;
              dh_q  <= dst_h_i;
              op_q  <= '0;
              st_q  <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: st_q <= ST_WAIT;
        default: begin
          if (div_done) begin
            case (op_q)
              2'd0: h_fact_o <= quo[SRC_W-1:0];
              2'd1: v_fact_o <= quo[SRC_W-1:0];
              2'd2: begin
                h_delta_o <= quo[DLT_W-1:0];
                h_init_o  <= init_val;
              end
              default: begin
                v_delta_o <= quo[DLT_W-1:0];
                v_init_o  <= init_val;
              end
            endcase
            if (op_q == 2'd3) begin
              st_q       <= ST_IDLE;
              done_o     <= 1'b1;
              scale_en_o <= 1'b1;
              enh_en_o   <= (h_fact_o[SRC_W-1:FRAC_BITS] >= INT_W'(2)) ||
                            (v_fact_o[SRC_W-1:FRAC_BITS] >= INT_W'(2));
            end else begin
              op_q <= op_q + 2'd1;
              st_q <= ST_ISSUE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/scl_phase_calc_chk.sv
module scl_phase_calc_chk #(
  parameter int unsigned LAYERS = 4,
  parameter int unsigned SRC_W  = 32,
  parameter int unsigned DST_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [LAYERS-1:0] req_mask_i,
  input logic [SRC_W-1:0]  src_w_i,
  input logic [SRC_W-1:0]  src_h_i,
  input logic [DST_W-1:0]  dst_w_i,
  input logic [DST_W-1:0]  dst_h_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              scale_en_o
);
  logic accept, any_zero;
  assign accept   = start_i && !busy_o;
  assign any_zero = (src_w_i == '0) || (src_h_i == '0) || (dst_w_i == '0) || (dst_h_i == '0);

  assert_zero_mask_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (req_mask_i == '0) |=> done_o && !err_o && !scale_en_o);

  assert_multi_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && ($countones(req_mask_i) > 1) |=> done_o && err_o);

  assert_err_noscale_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> !scale_en_o);

  assert_zero_size_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && ($countones(req_mask_i) == 1) && any_zero |=> done_o && err_o && !busy_o);

  assert_busy_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && ($countones(req_mask_i) == 1) && !any_zero |=> busy_o && !done_o);
endmodule

bind scl_phase_calc scl_phase_calc_chk #(
  .LAYERS(LAYERS), .SRC_W(SRC_W), .DST_W(DST_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .req_mask_i(req_mask_i),
  .src_w_i   (src_w_i),
  .src_h_i   (src_h_i),
  .dst_w_i   (dst_w_i),
  .dst_h_i   (dst_h_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .scale_en_o(scale_en_o)
);

// File: tb/scl_phase_calc_tb_top.sv
module scl_phase_calc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mask = '0;
  logic [31:0] sw = '0, sh = '0;
  logic [15:0] dw = '0, dh = '0;
  logic        busy, done, err, sen, enh;
  logic [31:0] hf, vf, hd, vd;
  logic [19:0] hi, vi;

  typedef struct {
    logic [170:0] val;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scl_phase_calc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_mask_i(mask),
    .src_w_i(sw), .src_h_i(sh), .dst_w_i(dw), .dst_h_i(dh),
    .busy_o(busy), .done_o(done), .err_o(err), .scale_en_o(sen), .enh_en_o(enh),
    .h_fact_o(hf), .v_fact_o(vf), .h_init_o(hi), .v_init_o(vi),
    .h_delta_o(hd), .v_delta_o(vd)
  );

  function automatic logic [170:0] pack_out();
    return {err, sen, enh, hf, vf, hd, vd, hi, vi};
  endfunction

  function automatic logic [170:0] model(logic [3:0] m, logic [31:0] s_w, logic [31:0] s_h,
                                         logic [15:0] d_w, logic [15:0] d_h);
    logic [63:0] f_h, f_v, i_w, i_h, dl_h, dl_v, in_h, in_v;
    logic        e;
    if (m == 0) return '0;
    if ((m & (m - 4'd1)) != 0) return {1'b1, 170'b0};
    if (s_w == 0 || s_h == 0 || d_w == 0 || d_h == 0) return {1'b1, 170'b0};
    f_h  = ((64'(d_w) << 32) / 64'(s_w)) & 64'hffff_ffff;
    f_v  = ((64'(d_h) << 32) / 64'(s_h)) & 64'hffff_ffff;
    i_w  = 64'(s_w) >> 16;
    i_h  = 64'(s_h) >> 16;
    dl_h = (i_w << 16) / 64'(d_w);
    dl_v = (i_h << 16) / 64'(d_h);
    in_h = ((i_w << 4) / 64'(d_w) + 1) / 2;
    in_v = ((i_h << 4) / 64'(d_h) + 1) / 2;
    e    = ((f_h >> 16) >= 2) || ((f_v >> 16) >= 2);
    return {1'b0, 1'b1, e, f_h[31:0], f_v[31:0], dl_h[31:0], dl_v[31:0], in_h[19:0], in_v[19:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [170:0] act, input logic [170:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] m, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] c, input logic [15:0] d, input string tag);
    exp_t it;
    it.val = model(m, a, b, c, d);
    it.tag = tag;
    q.push_back(it);
    mask = m; sw = a; sh = b; dw = c; dh = d;
    start = 1'b1;
  endtask

  task automatic drive(input logic [3:0] m, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] c, input logic [15:0] d, input string tag);
    @(negedge clk);
    push(m, a, b, c, d, tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || q.size() != 0);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R9 unexpected done", pack_out(), '0);
      end else begin
        exp_t it;
        it = q.pop_front();
        check(pack_out() === it.val, it.tag, pack_out(), it.val);
      end
    end
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired act=busy exp=idle");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, err, sen, enh, hf, vf, hd, vd, hi, vi} === '0, "R10 reset state",
          {busy, done, pack_out()}, '0);

    drive(4'b0000, 32'h0, 32'h0, 16'd0, 16'd0, "R1 zero mask");
    wait_idle();
    drive(4'b0110, 32'h0064_0000, 32'h0064_0000, 16'd100, 16'd100, "R2 two bits");
    wait_idle();
    drive(4'b1111, 32'h0064_0000, 32'h0064_0000, 16'd100, 16'd100, "R2 all bits");
    wait_idle();
    drive(4'b0001, 32'h0064_0000, 32'h0064_0000, 16'd100, 16'd0, "R3 zero dst_h");
    wait_idle();
    drive(4'b0010, 32'h0, 32'h0064_0000, 16'd100, 16'd100, "R3 zero src_w");
    wait_idle();
    drive(4'b0001, 32'h0064_0000, 32'h0064_0000, 16'd100, 16'd100, "R4 R5 R6 R8 identity");
    wait_idle();
    drive(4'b0100, 32'h0032_0000, 32'h0050_0000, 16'd100, 16'd80, "R7 h upscale 2x");
    wait_idle();
    drive(4'b1000, 32'h0080_0000, 32'h0032_0000, 16'd128, 16'd150, "R7 v upscale 3x");
    wait_idle();
    drive(4'b0001, 32'h0033_0000, 32'h003c_0000, 16'd100, 16'd90, "R7 below 2x");
    wait_idle();
    drive(4'b0010, 32'h0780_0000, 32'h0438_0000, 16'd640, 16'd360, "R5 downscale");
    wait_idle();
    drive(4'b0001, 32'h0001_8000, 32'h0002_4000, 16'd7, 16'd3, "R6 fractional src");
    wait_idle();
    drive(4'b0001, 32'h0000_0001, 32'h0000_0002, 16'd1, 16'd1, "R4 ratio truncation");
    wait_idle();

    // R9: start while busy is ignored
    drive(4'b0001, 32'h00a0_0000, 32'h0078_0000, 16'd320, 16'd240, "R9 busy run");
    repeat (20) @(negedge clk);
    mask = 4'b0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    check(q.size() == 0 && !busy && !done, "R9 ignored start", {168'b0, busy, done, 1'b0}, '0);

    // R9: back-to-back start in the done cycle
    drive(4'b0010, 32'h0010_0000, 32'h0010_0000, 16'd48, 16'd8, "R9 first of pair");
    do @(negedge clk); while (!done);
    push(4'b0100, 32'h0100_0000, 32'h0020_0000, 16'd64, 16'd96, "R9 second of pair");
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    check(q.size() == 0, "R9 queue drained", 171'(q.size()), '0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule